// File: doc/BRIEF.md
# Word-Addressed Serial Port Register Block

This block sits on a simple 32-bit register bus and connects a processor to a byte stream. It has three registers. Writing the transmit register sends the low byte of the written word out as a single strobed byte. Reading the receive register returns the one byte currently held and frees the holding slot in the same access. The status register reports whether a received byte is waiting and whether the transmit side can take a byte. The transmit side can always take a byte.

The incoming side is a valid/ready handshake. The block holds at most one received byte. It raises its ready output only while the holding slot is empty, so the byte source waits until software has read the previous byte. Writes to the status register are discarded. Offsets outside the three registers, and accesses narrower than a full word, read as zero and change nothing.

Top module: `sport_regs`

## Requirements
- R1: After reset the receive data reads 0, the status register reads 0x00000002, `rxReady` is 1 and `txValid` is 0.
- R2: Status bit 0 is receive-ready and bit 1 is transmit-ready. Bit 1 always reads 1 and bits 31:2 always read 0. Status sits at byte offset 0x14.
- R3: A full-word read of offset 0x04 returns the held byte zero-extended to 32 bits in the same cycle, and clears receive-ready at the next clock edge.
- R4: Reading the status register changes no state.
- R5: `rxReady` is the inverse of receive-ready. A byte offered with `rxValid` while receive-ready is set is not taken, and the held byte stays unchanged.
- R6: When `rxValid` and `rxReady` are both 1 at a clock edge, the byte on `rxData` is stored and receive-ready is set.
- R7: A full-word write to offset 0x00 makes `txValid` high for exactly the next cycle, with `txData` equal to bits 7:0 of the written word.
- R8: A write to the status register leaves receive-ready, the held byte and `txValid` unchanged.
- R9: An access whose byte enables are not all ones reads 0, sends no byte and clears nothing.
- R10: The register index is the byte address divided by four, so address bits 1:0 are ignored. Every index other than 0, 1 and 5 reads 0 and ignores writes. This includes all addresses from 0x18 upward. The transmit register also reads 0.
- R11: When a receive-register read and an accepted byte fall on the same clock edge, the read returns the old byte, the new byte is stored and receive-ready stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busBe | input | 4 | Byte enables; only 4'hF is a valid access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| txValid | output | 1 | Outgoing byte strobe |
| txData | output | 8 | Outgoing byte |
| rxValid | input | 1 | Incoming byte offered |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | Block can take an incoming byte |

## Verification
Two functions meet on one clock edge: software draining the receive register and the byte source delivering a new byte. Both act on the receive-ready flag, one clearing it and one setting it. The bench provokes this by issuing a receive read in the same cycle as an offered byte while the slot is empty. It then checks that the read returns the old byte, that status shows receive-ready still set, and that the next read returns the new byte. Random traffic mixes reads, status writes and offered bytes so that this overlap, and the case of a byte offered into a full slot, recur many times against the bench's own behavioural model.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int IDX_TX    = 0;
  localparam int IDX_RX    = 1;
  localparam int IDX_ST    = 5;
  localparam int WIN_BYTES = 24;

  typedef struct packed {
    logic rdRx;
    logic rdSt;
    logic wrTx;
    logic wrSt;
  } ctlStrobes_t;
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [WORD_W-1:0] busWdata,
  output ctlStrobes_t       strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx;
  logic             fullWord;
  logic             rdReq;
  logic             wrReq;

  assign regIdx   = busAddr[ADDR_W-1:2];
  assign fullWord = &busBe;
  assign rdReq    = busEn && !busWe && fullWord;
  assign wrReq    = busEn && busWe && fullWord;

  always_comb begin
    strobes      = '0;
    strobes.rdRx = rdReq && (regIdx == IDX_W'(IDX_RX));
    strobes.rdSt = rdReq && (regIdx == IDX_W'(IDX_ST));
    strobes.wrTx = wrReq && (regIdx == IDX_W'(IDX_TX));
    strobes.wrSt = wrReq && (regIdx == IDX_W'(IDX_ST));
  end

  p_known_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> !$isunknown(busAddr) && !$isunknown(busBe));
  p_known_wdata_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busWe) |-> !$isunknown(busWdata));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdRx, strobes.rdSt, strobes.wrTx, strobes.wrSt}));
  p_partial_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !fullWord) |-> (strobes == '0));
endmodule

// File: rtl/sport_dpath.sv
module sport_dpath
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic [WORD_W-1:0] busRdata
);
  logic              rxFull;
  logic [BYTE_W-1:0] rxHold;
  logic              rxTake;

  assign rxReady = !rxFull;
  assign rxTake  = rxValid && rxReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxHold <= '0;
    end else if (rxTake) begin
      rxFull <= 1'b1;
      rxHold <= rxData;
    end else if (strobes.rdRx) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strobes.wrTx;
      if (strobes.wrTx) txData <= busWdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdRx)      busRdata = {{(WORD_W-BYTE_W){1'b0}}, rxHold};
    else if (strobes.rdSt) busRdata = {{(WORD_W-2){1'b0}}, 1'b1, rxFull};
  end

  p_accept_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> rxFull && (rxHold == $past(rxData)));
  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !strobes.rdRx) |=> rxFull && $stable(rxHold));
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdRx && !rxValid) |=> !rxFull);
  p_overlap_keeps_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdRx && rxValid && rxReady) |=> rxFull);
  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrTx |=> txValid && (txData == $past(busWdata[BYTE_W-1:0])));
  p_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrTx |=> !txValid);
  p_status_wr_inert_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrSt && !rxValid) |=> $stable(rxFull) && $stable(rxHold));
  p_status_rd_inert_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSt && !rxTake) |=> $stable(rxFull));
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady
);
  ctlStrobes_t strobes;

  sport_ctrl #(.ADDR_W(ADDR_W), .BE_W(BE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .strobes(strobes)
  );

  sport_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .busRdata(busRdata)
  );

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe && (busAddr >= ADDR_W'(WIN_BYTES))) |-> (busRdata == '0));
  p_status_tx_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe && (&busBe) && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_ST)))
      |-> (busRdata[1] == 1'b1) && (busRdata[0] == !rxReady));
endmodule

// File: tb/sport_regs_tb.sv
module sport_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid;
  logic [7:0]  txData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;

  sport_regs dut_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  int       mFull;
  int       mHold;
  int       mTxV;
  int       mTxD;

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit en, bit we, int addr, int wd,
                      int be, bit rv, int rd);
    int expR;
    int idx;
    bit full;
    @(negedge clk);
    busEn = en; busWe = we; busAddr = addr[7:0]; busWdata = wd;
    busBe = be[3:0]; rxValid = rv; rxData = rd[7:0];
    #1;
    idx  = (addr & 8'hFF) >> 2;
    full = (be & 4'hF) == 4'hF;
    expR = 0;
    if (en && !we && full) begin
      if (idx == 1) expR = mHold;
      else if (idx == 5) expR = 2 | mFull;
    end
    cmp(req, "busRdata", busRdata, expR);
    cmp(req, "rxReady", int'(rxReady), mFull ? 0 : 1);
    cmp(req, "txValid", int'(txValid), mTxV);
    if (mTxV != 0) cmp(req, "txData", int'(txData), mTxD);
    // next-state of the model
    if (rv && !mFull) begin
      mFull = 1; mHold = rd & 8'hFF;
    end else if (en && !we && full && idx == 1) begin
      mFull = 0;
    end
    mTxV = (en && we && full && idx == 0) ? 1 : 0;
    if (mTxV != 0) mTxD = wd & 8'hFF;
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    int lcg;
    mFull = 0; mHold = 0; mTxV = 0; mTxD = 0;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "rxReady in reset", int'(rxReady), 1);
    cmp("R1", "txValid in reset", int'(txValid), 0);
    @(negedge clk); rstN = 1'b1;

    // R1 / R2: reset contents
    step("R1", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    step("R1", 1, 0, 8'h04, 0, 4'hF, 0, 0);
    // R6: accept a byte, R2 status shows both bits
    step("R6", 0, 0, 0, 0, 0, 1, 8'hA5);
    step("R2", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    // R4: repeated status reads keep the flag
    step("R4", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    // R5: byte offered into full slot is refused
    step("R5", 0, 0, 0, 0, 0, 1, 8'h5A);
    step("R5", 0, 0, 0, 0, 0, 1, 8'h3C);
    // R9: partial read of RX returns zero and does not clear
    step("R9", 1, 0, 8'h04, 0, 4'h1, 0, 0);
    // R8: status write ignored
    step("R8", 1, 1, 8'h14, 32'hFFFFFFFF, 4'hF, 0, 0);
    step("R8", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    // R3: read returns A5 and clears
    step("R3", 1, 0, 8'h04, 0, 4'hF, 0, 0);
    step("R3", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    // R7: transmit low byte, one-cycle pulse
    step("R7", 1, 1, 8'h00, 32'h123456C3, 4'hF, 0, 0);
    idle("R7");
    idle("R7");
    step("R7", 1, 1, 8'h00, 32'hFFFFFF00, 4'hF, 0, 0);
    step("R7", 1, 1, 8'h00, 32'h0000007E, 4'hF, 0, 0);
    idle("R7");
    // R9: partial write to TX sends nothing
    step("R9", 1, 1, 8'h00, 32'h11, 4'h3, 0, 0);
    idle("R9");
    // R10: unmapped and TX reads are zero; unmapped writes inert
    step("R10", 0, 0, 0, 0, 0, 1, 8'h77);
    step("R10", 1, 0, 8'h00, 0, 4'hF, 0, 0);
    step("R10", 1, 0, 8'h08, 0, 4'hF, 0, 0);
    step("R10", 1, 0, 8'h10, 0, 4'hF, 0, 0);
    step("R10", 1, 0, 8'h18, 0, 4'hF, 0, 0);
    step("R10", 1, 0, 8'hFC, 0, 4'hF, 0, 0);
    step("R10", 1, 1, 8'h1C, 32'hAB, 4'hF, 0, 0);
    step("R10", 1, 1, 8'h44, 32'hCD, 4'hF, 0, 0);
    // R10: low address bits ignored, 0x07 reads RX
    step("R10", 1, 0, 8'h07, 0, 4'hF, 0, 0);
    // R11: read with slot empty while a byte arrives
    step("R11", 1, 0, 8'h04, 0, 4'hF, 1, 8'h9E);
    step("R11", 1, 0, 8'h14, 0, 4'hF, 0, 0);
    step("R11", 1, 0, 8'h04, 0, 4'hF, 0, 0);
    // R11: read of full slot while a byte is offered (refused)
    step("R11", 0, 0, 0, 0, 0, 1, 8'h21);
    step("R11", 1, 0, 8'h04, 0, 4'hF, 1, 8'h42);
    step("R11", 1, 0, 8'h04, 0, 4'hF, 1, 8'h43);
    step("R11", 1, 0, 8'h14, 0, 4'hF, 0, 0);

    // mixed random traffic
    lcg = 32'h1234567;
    for (int i = 0; i < 3000; i++) begin
      int a;
      lcg = lcg * 1103515245 + 12345;
      case ((lcg >>> 8) & 7)
        0, 1: a = 8'h04;
        2, 3: a = 8'h14;
        4:    a = 8'h00;
        5:    a = (lcg >>> 16) & 8'hFF;
        default: a = 8'h04;
      endcase
      step("R11", ((lcg >>> 12) & 3) != 0, ((lcg >>> 14) & 3) == 0, a,
           lcg ^ 32'h5A5A5A5A, ((lcg >>> 20) & 7) == 0 ? ((lcg >>> 24) & 15) : 15,
           ((lcg >>> 19) & 1) != 0, (lcg >>> 3) & 8'hFF);
    end
    idle("R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule